// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a ring of receive descriptors in its own small register-based memory and retires one descriptor for every frame the frame writer finishes. Each descriptor is three 32-bit words: a status word that holds an ownership flag, a size word that holds the host-chosen buffer capacity in its upper half and the received length in its lower half, and a word with the buffer start address. The host fills descriptors through a word-addressed port and hands each one to the engine by setting its ownership flag. Meanwhile the frame writer reads the address and capacity of the current descriptor from dedicated outputs.

When the frame writer signals completion with a length and an error flag, the engine writes the length word first and the status word one cycle later. The status write-back releases ownership, records any error and keeps the end-of-ring marker. The engine then moves to the next slot, returning to slot 0 after a marked descriptor or after the last slot. A completion that finds the current descriptor still owned by the host is dropped and counted, and it also stops reception until the host enables it again.

Top module: `rxd_ring_engine`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `rx_en` is 0, `cur_idx` is 0, `missed_cnt` is 0, `fc_ready` is 1 and every descriptor word reads as 0.
- R2: Host port: word select 0 is the status word, 1 the size word and 2 the buffer address. A write with `host_we` high stores `host_wdata` in that word at the next clock edge. `host_rdata` shows the selected word in the same cycle. Word select 3 reads as 0, and a write to it changes no descriptor word.
- R3: `cur_buf_addr` equals word 2 of the current descriptor, and `cur_buf_size` equals bits 31:16 of its word 1. `cur_rdy` is high exactly when `rx_en` is 1 and bit 31 (owned-by-engine) of the current status word is 1.
- R4: A completion (`fc_valid` high while `fc_ready` and `cur_rdy` are high) drops `fc_ready` for two cycles. On the first edge after acceptance, bits 15:0 of word 1 receive the length and bits 31:16 keep their value. One edge later, the status word is rewritten with bit 31 cleared, bit 27 (error) set to the frame's error result, and every other bit (including bit 30, end-of-ring) kept.
- R5: If the reported length exceeds the descriptor's capacity, the stored length is the capacity and bit 27 is set even when `fc_err` is 0. A length equal to the capacity is stored unchanged.
- R6: `cur_idx` advances on the same edge as the status write. It goes to 0 when the retired descriptor had bit 30 set or was slot NUM_DESC-1, and otherwise to the next slot. It never changes at any other time.
- R7: A completion offered while `rx_en` is 1 and bit 31 of the current status word is 0 is taken in one cycle. It writes no descriptor word and leaves `cur_idx` unchanged. It raises `missed_cnt` by one, saturating at its maximum, and clears `rx_en` unless `rx_en_set` is high in the same cycle.
- R8: While `rx_en` is 0, `fc_valid` is ignored: no descriptor word, index or count changes, and `fc_ready` stays 1.
- R9: `rx_en_set` makes `rx_en` 1 on the next edge and wins over `rx_en_clr` and over a drop in the same cycle. `rx_en_clr` alone makes it 0.
- R10: If a host write and an engine write-back hit the same word on the same edge, the engine's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_idx | input | IDX_W | Host descriptor slot |
| host_word | input | 2 | Host word select (0 status, 1 size, 2 address) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected word, combinational |
| rx_en_set | input | 1 | Enable reception pulse |
| rx_en_clr | input | 1 | Disable reception pulse |
| rx_en | output | 1 | Reception enabled |
| fc_valid | input | 1 | Frame completed |
| fc_len | input | 16 | Completed frame length in bytes |
| fc_err | input | 1 | Completed frame had an error |
| fc_ready | output | 1 | Engine can take a completion |
| cur_rdy | output | 1 | Current descriptor usable by the frame writer |
| cur_buf_addr | output | 32 | Buffer address of current descriptor |
| cur_buf_size | output | 16 | Buffer capacity of current descriptor |
| cur_idx | output | IDX_W | Current slot |
| missed_cnt | output | CNT_W | Dropped completions, saturating |

## Verification
Two pairs of actions can land on the same clock edge. The first is a dropped completion, which clears enable, arriving with a host re-enable pulse; the bench drives `fc_valid` and `rx_en_set` in the same cycle against a host-owned descriptor and expects reception to stay on while the miss count still rises. The second is the engine's length write-back meeting a host write to the same size word; the bench places the host write in the cycle between acceptance and the length write and expects the engine's length, under the unchanged capacity, when it reads back.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int OWN_BIT  = 31;
    localparam int END_BIT  = 30;
    localparam int FAIL_BIT = 27;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_BUF  = 2'd2;
    localparam int WORDS_PER_DESC   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEN  = 2'd1,
        ST_STAT = 2'd2
    } rxr_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             bad;
    } rxr_frame_t;

    // Clamp a reported length to the buffer capacity and flag the overrun.
    function automatic rxr_frame_t clamp_frame(input logic [LEN_W-1:0] len,
                                               input logic [LEN_W-1:0] cap,
                                               input logic             err);
        rxr_frame_t f;
        if (len > cap) begin
            f.len = cap;
            f.bad = 1'b1;
        end else begin
            f.len = len;
            f.bad = err;
        end
        return f;
    endfunction

    // Status value written back: ownership released, error recorded,
    // every other bit carried over.
    function automatic logic [WORD_W-1:0] retire_status(input logic [WORD_W-1:0] old,
                                                        input logic              bad);
        logic [WORD_W-1:0] s;
        s           = old;
        s[OWN_BIT]  = 1'b0;
        s[FAIL_BIT] = bad;
        return s;
    endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
`timescale 1ns/1ps
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [1:0]        host_word,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic              eng_len_we,
    input  logic [LEN_W-1:0]  eng_len,
    input  logic              eng_stat_we,
    input  logic [WORD_W-1:0] eng_stat,
    output logic [WORD_W-1:0] cur_stat,
    output logic [WORD_W-1:0] cur_size,
    output logic [WORD_W-1:0] cur_buf
);

    localparam int NUM_WORDS = NUM_DESC * WORDS_PER_DESC;

    logic [WORD_W-1:0] words [NUM_WORDS];

    logic host_hit_ok;
    assign host_hit_ok = (host_word != 2'd3) && (int'(host_idx) < NUM_DESC);

    for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
        for (genvar w = 0; w < WORDS_PER_DESC; w++) begin : g_word
            localparam int SLOT = d * WORDS_PER_DESC + w;
            logic host_hit;
            logic eng_hit;
            logic [WORD_W-1:0] eng_val;

            assign host_hit = host_we && host_hit_ok &&
                              (int'(host_idx) == d) && (int'(host_word) == w);

            if (w == int'(SEL_STAT)) begin : g_stat
                assign eng_hit = eng_stat_we && (int'(eng_idx) == d);
                assign eng_val = eng_stat;
            end else if (w == int'(SEL_SIZE)) begin : g_size
                assign eng_hit = eng_len_we && (int'(eng_idx) == d);
                assign eng_val = {words[SLOT][WORD_W-1:LEN_W], eng_len};
            end else begin : g_buf
                assign eng_hit = 1'b0;
                assign eng_val = words[SLOT];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    words[SLOT] <= '0;
                end else if (eng_hit) begin
                    words[SLOT] <= eng_val;
                end else if (host_hit) begin
                    words[SLOT] <= host_wdata;
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_hit_ok) begin
            host_rdata = words[int'(host_idx) * WORDS_PER_DESC + int'(host_word)];
        end
    end

    assign cur_stat = words[int'(eng_idx) * WORDS_PER_DESC + int'(SEL_STAT)];
    assign cur_size = words[int'(eng_idx) * WORDS_PER_DESC + int'(SEL_SIZE)];
    assign cur_buf  = words[int'(eng_idx) * WORDS_PER_DESC + int'(SEL_BUF)];

endmodule

// File: rtl/rxr_miss_cnt.sv
`timescale 1ns/1ps
module rxr_miss_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fc_valid,
    input  logic [LEN_W-1:0]  fc_len,
    input  logic              fc_err,
    input  logic              rx_en_set,
    input  logic              rx_en_clr,
    input  logic [WORD_W-1:0] cur_stat,
    input  logic [LEN_W-1:0]  cur_cap,
    output logic              fc_ready,
    output logic              rx_en,
    output logic [IDX_W-1:0]  idx,
    output logic              eng_len_we,
    output logic [LEN_W-1:0]  eng_len,
    output logic              eng_stat_we,
    output logic [WORD_W-1:0] eng_stat,
    output logic              miss_bump
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    rxr_state_e state_q;
    rxr_frame_t frame_q;
    rxr_frame_t fitted;
    logic       accept;
    logic       take;
    logic       drop;
    logic [IDX_W-1:0] idx_next;

    assign fc_ready = (state_q == ST_IDLE);
    assign accept   = fc_valid && fc_ready && rx_en;
    assign take     = accept && cur_stat[OWN_BIT];
    assign drop     = accept && !cur_stat[OWN_BIT];
    assign fitted   = clamp_frame(fc_len, cur_cap, fc_err);

    assign eng_len_we  = (state_q == ST_LEN);
    assign eng_len     = frame_q.len;
    assign eng_stat_we = (state_q == ST_STAT);
    assign eng_stat    = retire_status(cur_stat, frame_q.bad);
    assign miss_bump   = drop;

    always_comb begin
        if (cur_stat[END_BIT] || (idx == LAST_IDX)) begin
            idx_next = '0;
        end else begin
            idx_next = idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            idx     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        frame_q <= fitted;
                        state_q <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    state_q <= ST_STAT;
                end
                ST_STAT: begin
                    idx     <= idx_next;
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
        end else if (rx_en_set) begin
            rx_en <= 1'b1;
        end else if (rx_en_clr || drop) begin
            rx_en <= 1'b0;
        end
    end

endmodule

// File: rtl/rxd_ring_engine.sv
`timescale 1ns/1ps
module rxd_ring_engine
    import rxr_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [1:0]       host_word,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             rx_en_set,
    input  logic             rx_en_clr,
    output logic             rx_en,
    input  logic             fc_valid,
    input  logic [15:0]      fc_len,
    input  logic             fc_err,
    output logic             fc_ready,
    output logic             cur_rdy,
    output logic [31:0]      cur_buf_addr,
    output logic [15:0]      cur_buf_size,
    output logic [IDX_W-1:0] cur_idx,
    output logic [CNT_W-1:0] missed_cnt
);

    logic [WORD_W-1:0] cur_stat;
    logic [WORD_W-1:0] cur_size;
    logic [WORD_W-1:0] cur_buf;
    logic              eng_len_we;
    logic [LEN_W-1:0]  eng_len;
    logic              eng_stat_we;
    logic [WORD_W-1:0] eng_stat;
    logic              miss_bump;

    rxr_desc_mem #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_mem (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_idx    (host_idx),
        .host_word   (host_word),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .eng_idx     (cur_idx),
        .eng_len_we  (eng_len_we),
        .eng_len     (eng_len),
        .eng_stat_we (eng_stat_we),
        .eng_stat    (eng_stat),
        .cur_stat    (cur_stat),
        .cur_size    (cur_size),
        .cur_buf     (cur_buf)
    );

    rxr_ctrl #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .fc_valid    (fc_valid),
        .fc_len      (fc_len),
        .fc_err      (fc_err),
        .rx_en_set   (rx_en_set),
        .rx_en_clr   (rx_en_clr),
        .cur_stat    (cur_stat),
        .cur_cap     (cur_size[WORD_W-1:LEN_W]),
        .fc_ready    (fc_ready),
        .rx_en       (rx_en),
        .idx         (cur_idx),
        .eng_len_we  (eng_len_we),
        .eng_len     (eng_len),
        .eng_stat_we (eng_stat_we),
        .eng_stat    (eng_stat),
        .miss_bump   (miss_bump)
    );

    rxr_miss_cnt #(
        .CNT_W (CNT_W)
    ) u_miss (
        .clk   (clk),
        .rst   (rst),
        .bump  (miss_bump),
        .count (missed_cnt)
    );

    assign cur_rdy      = rx_en && cur_stat[OWN_BIT];
    assign cur_buf_addr = cur_buf;
    assign cur_buf_size = cur_size[WORD_W-1:LEN_W];

endmodule

// File: rtl/rxr_chk.sv
`timescale 1ns/1ps
module rxr_chk #(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fc_valid,
    input logic             fc_ready,
    input logic             cur_rdy,
    input logic             rx_en,
    input logic             rx_en_clr,
    input logic [IDX_W-1:0] cur_idx,
    input logic [CNT_W-1:0] missed_cnt,
    input logic [15:0]      cur_buf_size,
    input logic             eng_len_we,
    input logic             eng_stat_we,
    input logic [15:0]      eng_len
);

    // R6
    idx_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cur_idx) < NUM_DESC);

    // R6
    idx_moves_on_status_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_idx != $past(cur_idx)) |-> $past(eng_stat_we));

    // R4
    length_before_status_chk: assert property (@(posedge clk) disable iff (rst)
        eng_stat_we |-> $past(eng_len_we));

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (fc_valid && fc_ready && cur_rdy) |=> !fc_ready);

    // R5
    length_fits_chk: assert property (@(posedge clk) disable iff (rst)
        eng_len_we |-> (eng_len <= cur_buf_size));

    // R7
    miss_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + CNT_W'(1)));

    // R9
    enable_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_en) |-> ($past(rx_en_clr) || $past(fc_valid && fc_ready && !cur_rdy)));

endmodule

bind rxd_ring_engine rxr_chk #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
) u_rxr_chk (
    .clk          (clk),
    .rst          (rst),
    .fc_valid     (fc_valid),
    .fc_ready     (fc_ready),
    .cur_rdy      (cur_rdy),
    .rx_en        (rx_en),
    .rx_en_clr    (rx_en_clr),
    .cur_idx      (cur_idx),
    .missed_cnt   (missed_cnt),
    .cur_buf_size (cur_buf_size),
    .eng_len_we   (eng_len_we),
    .eng_stat_we  (eng_stat_we),
    .eng_len      (eng_len)
);

// File: tb/test_rxd_ring_engine.sv
`timescale 1ns/1ps
module test_rxd_ring_engine;

    localparam int N = 4;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] ENDR = 32'h4000_0000;
    localparam logic [31:0] FAIL = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_we;
    logic [1:0]  host_idx;
    logic [1:0]  host_word;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        rx_en_set, rx_en_clr, rx_en;
    logic        fc_valid;
    logic [15:0] fc_len;
    logic        fc_err;
    logic        fc_ready, cur_rdy;
    logic [31:0] cur_buf_addr;
    logic [15:0] cur_buf_size;
    logic [1:0]  cur_idx;
    logic [7:0]  missed_cnt;

    int checks = 0;
    int fails  = 0;
    int exp_idx = 0;
    int exp_miss = 0;
    logic [3:0] endmask = 4'b1000;

    always #2 clk = ~clk;

    rxd_ring_engine #(.NUM_DESC(N), .CNT_W(8)) i_rxd_ring_engine (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_idx(host_idx), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_en_set(rx_en_set), .rx_en_clr(rx_en_clr), .rx_en(rx_en),
        .fc_valid(fc_valid), .fc_len(fc_len), .fc_err(fc_err), .fc_ready(fc_ready),
        .cur_rdy(cur_rdy), .cur_buf_addr(cur_buf_addr), .cur_buf_size(cur_buf_size),
        .cur_idx(cur_idx), .missed_cnt(missed_cnt)
    );

    function automatic logic [15:0] cap_of(input int i);
        return 16'(64 + 16 * i);
    endfunction

    function automatic logic [31:0] buf_of(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic hw(input int i, input int w, input logic [31:0] d);
        host_we = 1'b1; host_idx = 2'(i); host_word = 2'(w); host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input int i, input int w, output logic [31:0] d);
        host_idx = 2'(i); host_word = 2'(w);
        #0.5;
        d = host_rdata;
    endtask

    task automatic pulse_set();
        rx_en_set = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_en_set = 1'b0;
    endtask

    function automatic logic [31:0] arm_word(input int i, input bit pre_fail);
        return OWN | (endmask[i] ? ENDR : 32'h0) | (pre_fail ? FAIL : 32'h0) | 32'h5A00 | 32'(i);
    endfunction

    task automatic good_frame(input logic [15:0] len, input bit err, input bit pre_fail);
        logic [31:0] rd, armed;
        logic [15:0] cap, eff;
        bit bad;
        int i;
        i = exp_idx;
        cap = cap_of(i);
        armed = arm_word(i, pre_fail);
        hw(i, 1, {cap, 16'hBEEF});
        hw(i, 0, armed);
        chk("R3 cur_rdy", 32'(cur_rdy), 32'd1);
        chk("R3 buf addr", cur_buf_addr, buf_of(i));
        chk("R3 buf size", 32'(cur_buf_size), 32'(cap));
        eff = (len > cap) ? cap : len;
        bad = err || (len > cap);
        fc_valid = 1'b1; fc_len = len; fc_err = err;
        @(posedge clk); @(negedge clk);
        fc_valid = 1'b0;
        chk("R4 busy", 32'(fc_ready), 32'd0);
        @(posedge clk); @(negedge clk);
        hr(i, 1, rd);
        if (len > cap) chk("R5 clamped length", rd, {cap, cap});
        else           chk("R4 length word", rd, {cap, len});
        hr(i, 0, rd);
        chk("R4 status still owned", rd, armed);
        @(posedge clk); @(negedge clk);
        hr(i, 0, rd);
        chk("R4 R5 status write-back", rd, (armed & ~OWN & ~FAIL) | (bad ? FAIL : 32'h0));
        chk("R4 ready again", 32'(fc_ready), 32'd1);
        exp_idx = (endmask[i] || i == N - 1) ? 0 : i + 1;
        chk("R6 index", 32'(cur_idx), 32'(exp_idx));
    endtask

    initial begin
        logic [31:0] rd;
        rst = 1'b1; host_we = 0; host_idx = 0; host_word = 0; host_wdata = 0;
        rx_en_set = 0; rx_en_clr = 0; fc_valid = 0; fc_len = 0; fc_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 rx_en", 32'(rx_en), 32'd0);
        chk("R1 idx", 32'(cur_idx), 32'd0);
        chk("R1 missed", 32'(missed_cnt), 32'd0);
        chk("R1 ready", 32'(fc_ready), 32'd1);
        for (int i = 0; i < N; i++)
            for (int w = 0; w < 3; w++) begin
                hr(i, w, rd);
                chk("R1 word zero", rd, 32'h0);
            end

        // R8 completion while disabled
        fc_valid = 1'b1; fc_len = 16'd20;
        @(posedge clk); @(negedge clk);
        fc_valid = 1'b0;
        chk("R8 ready", 32'(fc_ready), 32'd1);
        chk("R8 missed", 32'(missed_cnt), 32'd0);
        chk("R8 idx", 32'(cur_idx), 32'd0);
        hr(0, 1, rd);
        chk("R8 word untouched", rd, 32'h0);

        // R2 host programming
        for (int i = 0; i < N; i++) begin
            hw(i, 2, buf_of(i));
            hw(i, 1, {cap_of(i), 16'h0});
        end
        for (int i = 0; i < N; i++) begin
            hr(i, 2, rd);
            chk("R2 addr readback", rd, buf_of(i));
        end
        hw(1, 3, 32'hDEAD_BEEF);
        hr(1, 3, rd);
        chk("R2 select 3 reads zero", rd, 32'h0);
        for (int w = 0; w < 3; w++) begin
            hr(1, w, rd);
            chk("R2 select 3 no write", rd, (w == 2) ? buf_of(1) : (w == 1) ? {cap_of(1), 16'h0} : 32'h0);
        end

        // R9 enable
        pulse_set();
        chk("R9 set", 32'(rx_en), 32'd1);
        chk("R3 not owned", 32'(cur_rdy), 32'd0);

        // Sweep of lengths and error flags across several laps
        for (int k = 0; k < 24; k++) begin
            good_frame(16'((k * 29) % (int'(cap_of(exp_idx)) + 24)), (k % 3) == 0, k[0]);
        end
        // Capacity boundaries
        good_frame(cap_of(exp_idx), 1'b0, 1'b1);
        good_frame(cap_of(exp_idx) + 16'd1, 1'b0, 1'b0);
        good_frame(16'd0, 1'b0, 1'b1);
        good_frame(16'hFFFF, 1'b1, 1'b0);

        // R6 early wrap on end marker at slot 2
        while (exp_idx != 0) good_frame(16'd10, 1'b0, 1'b0);
        endmask = 4'b0100;
        for (int k = 0; k < 6; k++) good_frame(16'(k + 1), 1'b0, 1'b0);
        chk("R6 wrap lap", 32'(cur_idx), 32'(exp_idx));

        // R7 drop on host-owned descriptor
        hw(exp_idx, 0, 32'h0000_0033);
        hw(exp_idx, 1, {cap_of(exp_idx), 16'h7777});
        fc_valid = 1'b1; fc_len = 16'd5;
        @(posedge clk); @(negedge clk);
        fc_valid = 1'b0;
        exp_miss++;
        chk("R7 missed", 32'(missed_cnt), 32'(exp_miss));
        chk("R7 rx_en cleared", 32'(rx_en), 32'd0);
        chk("R7 idx held", 32'(cur_idx), 32'(exp_idx));
        chk("R7 ready", 32'(fc_ready), 32'd1);
        hr(exp_idx, 1, rd);
        chk("R7 length untouched", rd, {cap_of(exp_idx), 16'h7777});
        hr(exp_idx, 0, rd);
        chk("R7 status untouched", rd, 32'h0000_0033);

        // R7 saturation
        for (int k = 0; k < 260; k++) begin
            pulse_set();
            fc_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            fc_valid = 1'b0;
        end
        chk("R7 saturates", 32'(missed_cnt), 32'd255);
        chk("R7 idx still held", 32'(cur_idx), 32'(exp_idx));

        // R9 set beats clear
        rx_en_set = 1'b1; rx_en_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_en_set = 1'b0; rx_en_clr = 1'b0;
        chk("R9 set over clear", 32'(rx_en), 32'd1);
        rx_en_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_en_clr = 1'b0;
        chk("R9 clear", 32'(rx_en), 32'd0);

        // R9 set beats drop in the same cycle (counter in saturation: restart it)
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        exp_idx = 0; exp_miss = 0; endmask = 4'b1000;
        pulse_set();
        fc_valid = 1'b1; rx_en_set = 1'b1;
        @(posedge clk); @(negedge clk);
        fc_valid = 1'b0; rx_en_set = 1'b0;
        chk("R9 set over drop", 32'(rx_en), 32'd1);
        chk("R9 drop still counted", 32'(missed_cnt), 32'd1);

        // R10 host write colliding with length write-back
        hw(0, 2, buf_of(0));
        hw(0, 1, {cap_of(0), 16'h0});
        hw(0, 0, arm_word(0, 1'b0));
        fc_valid = 1'b1; fc_len = 16'd42; fc_err = 1'b0;
        @(posedge clk); @(negedge clk);
        fc_valid = 1'b0;
        host_we = 1'b1; host_idx = 2'd0; host_word = 2'd1; host_wdata = 32'h1234_5678;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
        hr(0, 1, rd);
        chk("R10 engine wins", rd, {cap_of(0), 16'd42});
        @(posedge clk); @(negedge clk);
        chk("R10 idx advanced", 32'(cur_idx), 32'd1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=completion");
        summary();
        $finish;
    end

endmodule